// File: doc/BRIEF.md
# Flash Program and Erase Status Engine

This block sits between a flash command decoder and a byte-wide synchronous array. It accepts one-byte program requests and whole-array erase requests. A clock-cycle counter stands in for the self-timed internal operation, and the block drives the array write port to carry each request out. A program only clears bits: the engine reads the old byte, ANDs it with the new byte and writes the result back. An erase writes the erased value, all ones, one address per clock. When the protect flag is set at the start of an erase, the protected low region is left alone.

While an operation runs, host reads return a status byte in place of array contents. Bit 7 is a data-poll bit and bit 6 is a toggle bit. Once the operation ends, reads return true array data again and a new request is accepted. A registered busy output lets the command decoder hold off new commands.

Top module: `flash_op_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and rd_valid are 0 and the array write enable is 0.
- R2: When idle, a read strobe returns the array byte at rd_addr on rd_data, with rd_valid high exactly two cycles after the strobe cycle.
- R3: A program request accepted while idle raises busy from the next cycle for exactly PROG_CYCLES cycles. The byte at the target address becomes old value AND new value.
- R4: A status byte carries, at bit 7, the inverse of bit 7 of the byte being programmed, or 0 during an erase. Bits 5 down to 0 read as 0.
- R5: Bit 6 of the status byte is 0 on the first read of an operation and inverts on each further read while busy. Reads after busy falls return array data.
- R6: An erase writes 0xFF to every address from the sweep base to the top of the array, one per clock. Busy stays high for the larger of ERASE_CYCLES and the number of swept addresses.
- R7: If lock_boot is 1 when an erase or program starts, addresses below BOOT_SIZE are not written. A locked erase sweeps only from BOOT_SIZE upward. A locked program is still timed for PROG_CYCLES.
- R8: Requests that arrive while busy are ignored. If a program and an erase request arrive together while idle, the erase is started.
- R9: A read strobe in the same cycle as an accepted request returns a status byte, not array data.
- R10: A request presented in the first cycle that busy is low is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | Program request strobe |
| prog_addr | input | ADDR_W | Program target address |
| prog_data | input | 8 | Program data |
| erase_req | input | 1 | Erase request strobe |
| lock_boot | input | 1 | Protect the low region below BOOT_SIZE |
| rd_req | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_valid | output | 1 | Read data valid, two cycles after rd_req |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Operation in progress |
| arr_addr | output | ADDR_W | Array address |
| arr_re | output | 1 | Array read enable, data one cycle later |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data |

## Verification
A wrong operation state or timer count shows on busy in the cycle it goes wrong. It also shows two cycles later on any read, which returns status where data was expected, or the other way round. A toggle or poll register that is wrong shows on the next status read. A bad read-modify-write or sweep address corrupts array contents. That corruption appears on the first idle read of the damaged address and in a full array comparison at the end.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t ERASED_VAL = '1;
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRD,
    ST_PWR,
    ST_PWAIT,
    ST_ERASE
  } op_state_t;

  function automatic byte_t status_word(input logic poll, input logic tog);
    byte_t w;
    w = '0;
    w[POLL_BIT]   = poll;
    w[TOGGLE_BIT] = tog;
    return w;
  endfunction
endpackage

// File: rtl/fse_timer.sv
module fse_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] limit_in,
  input  logic          run,
  output logic          reached
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
      lim_q <= limit_in;
    end else if (run && (cnt_q < lim_q)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign reached = (cnt_q >= lim_q);

  p_timer_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_q);
endmodule

// File: rtl/fse_sweep.sv
module fse_sweep #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          active,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic          act_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      addr_q <= base;
    end else if (act_q) begin
      if (addr_q == '1) act_q <= 1'b0;
      else              addr_q <= addr_q + AW'(1);
    end
  end

  assign active = act_q;
  assign addr   = addr_q;
  assign last   = act_q && (addr_q == '1);

  p_sweep_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
    (act_q && !start && $past(act_q)) |-> (addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: rtl/fse_status.sv
module fse_status
  import fse_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_req,
  input  logic  status_sel,
  input  logic  op_start,
  input  logic  poll_bit,
  input  byte_t arr_rdata,
  output logic  rd_valid,
  output byte_t rd_data
);
  logic  tog_q;
  logic  tog_use;
  logic  p1_v_q, p1_st_q;
  byte_t p1_word_q;
  logic  v_q;
  byte_t d_q;

  assign tog_use = op_start ? 1'b0 : tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q <= 1'b0;
    end else if (op_start) begin
      tog_q <= rd_req;
    end else if (status_sel && rd_req) begin
      tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_v_q    <= 1'b0;
      p1_st_q   <= 1'b0;
      p1_word_q <= '0;
      v_q       <= 1'b0;
      d_q       <= '0;
    end else begin
      p1_v_q    <= rd_req;
      p1_st_q   <= status_sel;
      p1_word_q <= status_word(poll_bit, tog_use);
      v_q       <= p1_v_q;
      if (p1_v_q) d_q <= p1_st_q ? p1_word_q : arr_rdata;
    end
  end

  assign rd_valid = v_q;
  assign rd_data  = d_q;

  p_toggle_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_req && status_sel && !op_start) |=> (tog_q != $past(tog_q)));
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req, 2));
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import fse_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int BOOT_SIZE    = 8192,
  parameter int PROG_CYCLES  = 2500,
  parameter int ERASE_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_req,
  input  logic              lock_boot,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_re,
  output logic              arr_we,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXT  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int MAXV  = (MAXT > DEPTH) ? MAXT : DEPTH;
  localparam int CW    = $clog2(MAXV + 1);
  localparam logic [CW-1:0]     PROG_L  = CW'(PROG_CYCLES);
  localparam logic [CW-1:0]     ERASE_L = CW'(ERASE_CYCLES);
  localparam logic [ADDR_W-1:0] BOOT_A  = ADDR_W'(BOOT_SIZE);

  op_state_t         state_q;
  logic [ADDR_W-1:0] paddr_q;
  byte_t             pdata_q;
  logic              pblock_q;
  logic              elock_q;
  logic              b7_q;

  logic idle, op_start, start_erase, start_prog;
  logic t_reached;
  logic sw_active, sw_last;
  logic [ADDR_W-1:0] sw_addr;
  logic [ADDR_W-1:0] sweep_base;
  logic prog_lock;
  logic cur_poll;

  assign idle        = (state_q == ST_IDLE);
  assign busy        = !idle;
  assign start_erase = idle && erase_req;
  assign start_prog  = idle && prog_req && !erase_req;
  assign op_start    = start_erase || start_prog;

  generate
    if (BOOT_SIZE > 0) begin : g_lock
      assign sweep_base = lock_boot ? BOOT_A : '0;
      assign prog_lock  = lock_boot && (prog_addr < BOOT_A);
    end else begin : g_nolock
      assign sweep_base = '0;
      assign prog_lock  = 1'b0;
    end
  endgenerate

  fse_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (op_start),
    .limit_in (start_erase ? ERASE_L : PROG_L),
    .run      (busy),
    .reached  (t_reached)
  );

  fse_sweep #(.AW(ADDR_W)) u_sweep (
    .clk    (clk),
    .rst    (rst),
    .start  (start_erase),
    .base   (sweep_base),
    .active (sw_active),
    .addr   (sw_addr),
    .last   (sw_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      paddr_q  <= '0;
      pdata_q  <= '0;
      pblock_q <= 1'b0;
      elock_q  <= 1'b0;
      b7_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_erase) begin
            state_q <= ST_ERASE;
            elock_q <= lock_boot;
            b7_q    <= 1'b0;
          end else if (start_prog) begin
            state_q  <= ST_PRD;
            paddr_q  <= prog_addr;
            pdata_q  <= prog_data;
            pblock_q <= prog_lock;
            b7_q     <= ~prog_data[POLL_BIT];
          end
        end
        ST_PRD:   state_q <= ST_PWR;
        ST_PWR:   state_q <= t_reached ? ST_IDLE : ST_PWAIT;
        ST_PWAIT: if (t_reached) state_q <= ST_IDLE;
        ST_ERASE: if (t_reached && (!sw_active || sw_last)) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    arr_addr  = rd_addr;
    arr_wdata = arr_rdata & pdata_q;
    arr_we    = 1'b0;
    arr_re    = idle && rd_req && !op_start;
    case (state_q)
      ST_PRD: begin
        arr_addr = paddr_q;
        arr_re   = 1'b1;
      end
      ST_PWR: begin
        arr_addr = paddr_q;
        arr_we   = !pblock_q;
      end
      ST_ERASE: begin
        arr_addr  = sw_addr;
        arr_wdata = ERASED_VAL;
        arr_we    = sw_active;
      end
      default: ;
    endcase
  end

  assign cur_poll = busy ? b7_q : (erase_req ? 1'b0 : ~prog_data[POLL_BIT]);

  fse_status u_status (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .status_sel (busy || op_start),
    .op_start   (op_start),
    .poll_bit   (cur_poll),
    .arr_rdata  (arr_rdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  p_idle_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    idle |-> !arr_we);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
  p_erase_end_r6: assert property (@(posedge clk) disable iff (rst)
    (idle && $past(state_q) == ST_ERASE) |-> $past(!sw_active || sw_last));
  p_boot_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (arr_we && state_q == ST_ERASE && elock_q) |-> (arr_addr >= BOOT_A));
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q == ST_PWAIT && !t_reached) |=> (state_q == ST_PWAIT));
endmodule

// File: tb/tb_flash_op_engine.sv
module tb_flash_op_engine;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int BOOT  = 128;
  localparam int PROGC = 12;
  localparam int ERAC  = 1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic prog_req = 0, erase_req = 0, lock_boot = 0, rd_req = 0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [7:0] prog_data = '0;
  logic rd_valid, busy, arr_re, arr_we;
  logic [7:0] rd_data, arr_wdata, arr_rdata;
  logic [AW-1:0] arr_addr;

  flash_op_engine #(.ADDR_W(AW), .BOOT_SIZE(BOOT), .PROG_CYCLES(PROGC),
                    .ERASE_CYCLES(ERAC)) dut (
    .clk(clk), .rst(rst), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .lock_boot(lock_boot),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .arr_addr(arr_addr), .arr_re(arr_re), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata));

  // array storage outside the block
  logic [7:0] ram [DEPTH];
  logic [7:0] ram_q = '0;
  always @(posedge clk) begin
    if (arr_we) ram[arr_addr] <= arr_wdata;
    if (arr_re) ram_q <= ram[arr_addr];
  end
  assign arr_rdata = ram_q;

  // reference model
  logic [7:0] ref_mem [DEPTH];
  int   m_left = 0;
  logic m_b7 = 0, m_tog = 0;
  logic p1_v = 0, exp_valid = 0, exp_busy = 0;
  logic p1_st = 0, exp_st = 0;
  logic [7:0] p1_d = '0, exp_data = '0;
  logic seen_edge = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_tog = 0; m_b7 = 0; p1_v = 0; exp_valid = 0; exp_busy = 0;
      seen_edge = 1;
    end else begin
      logic bz, st;
      bz = (m_left > 0);
      exp_valid = p1_v; exp_data = p1_d; exp_st = p1_st;
      st = !bz && (prog_req || erase_req);
      p1_v = rd_req; p1_st = 0;
      if (rd_req) begin
        if (bz) begin
          p1_d = {m_b7, m_tog, 6'b0}; m_tog = ~m_tog; p1_st = 1;
        end else if (st) begin
          p1_d = {(erase_req ? 1'b0 : ~prog_data[7]), 7'b0}; p1_st = 1;
        end else p1_d = ref_mem[rd_addr];
      end
      if (bz) m_left--;
      if (st) begin
        m_tog = rd_req;
        if (erase_req) begin
          int base;
          base = lock_boot ? BOOT : 0;
          for (int a = base; a < DEPTH; a++) ref_mem[a] = 8'hFF;
          m_left = (DEPTH - base > ERAC) ? DEPTH - base : ERAC;
          m_b7 = 0;
        end else begin
          if (!(lock_boot && prog_addr < BOOT))
            ref_mem[prog_addr] = ref_mem[prog_addr] & prog_data;
          m_left = PROGC;
          m_b7 = ~prog_data[7];
        end
      end
      exp_busy = (m_left > 0);
    end
  end

  int checks = 0, errors = 0;
  string cur_tag = "R1";
  bit finished = 0;

  always @(negedge clk) begin
    if (seen_edge && !finished) begin
      if (rst) begin
        checks++;
        if (busy !== 0 || rd_valid !== 0 || arr_we !== 0) begin
          errors++;
          $display("FAIL R1 reset outputs busy=%b rd_valid=%b we=%b exp 0 0 0", busy, rd_valid, arr_we);
        end
      end else begin
        checks++;
        if (busy !== exp_busy) begin
          errors++;
          $display("FAIL %s busy got %b exp %b", cur_tag, busy, exp_busy);
        end
        checks++;
        if (rd_valid !== exp_valid) begin
          errors++;
          $display("FAIL R2 rd_valid got %b exp %b", rd_valid, exp_valid);
        end else if (exp_valid) begin
          checks++;
          if (rd_data !== exp_data) begin
            errors++;
            $display("FAIL %s rd_data got %h exp %h", exp_st ? "R4 R5 R9" : cur_tag, rd_data, exp_data);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d exp completion", cyc);
      finish_run();
    end
  end

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); rd_req = 1; rd_addr = a;
    @(negedge clk); rd_req = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic req(input logic p, input logic e, input logic r,
                     input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_req = p; erase_req = e; rd_req = r; prog_addr = a; prog_data = d; rd_addr = a;
    @(negedge clk);
    prog_req = 0; erase_req = 0; rd_req = 0;
  endtask

  task automatic poll_idle();
    while (busy) begin
      rd_req = 1; rd_addr = prog_addr;
      @(negedge clk);
    end
    rd_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = 8'((i * 37 + 5) & 8'hFF);
      ref_mem[i] = 8'((i * 37 + 5) & 8'hFF);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R2";
    rd(0); rd(1); rd(100); rd(10'(DEPTH - 1));
    cur_tag = "R3";
    req(1, 0, 0, 5, 8'h3C); poll_idle(); rd(5);
    req(1, 0, 0, 700, 8'h81); poll_idle(); rd(700);
    req(1, 0, 0, 701, 8'hF0); quiet_idle(); rd(701);
    cur_tag = "R9";
    req(1, 0, 1, 9, 8'h0F); poll_idle(); rd(9);
    cur_tag = "R8";
    req(1, 0, 0, 20, 8'hAA);
    req(1, 0, 0, 21, 8'h00);
    req(0, 1, 0, 22, 8'h00);
    quiet_idle(); rd(20); rd(21); rd(22);
    cur_tag = "R8 R6";
    req(1, 1, 0, 30, 8'h00); poll_idle();
    cur_tag = "R6";
    rd(0); rd(30); rd(500); rd(10'(DEPTH - 1));
    cur_tag = "R7";
    req(1, 0, 0, 3, 8'h12); quiet_idle();
    req(1, 0, 0, 200, 8'h34); quiet_idle();
    lock_boot = 1;
    req(0, 1, 0, 0, 8'h00); poll_idle();
    req(1, 0, 0, 4, 8'h00); poll_idle();
    lock_boot = 0;
    rd(3); rd(4); rd(200); rd(10'(BOOT));
    cur_tag = "R10";
    req(1, 0, 0, 40, 8'h55);
    while (busy) @(negedge clk);
    prog_req = 1; prog_addr = 41; prog_data = 8'h66;
    @(negedge clk); prog_req = 0;
    poll_idle(); rd(40); rd(41);
    checks++;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < DEPTH; i++) if (ram[i] !== ref_mem[i]) bad++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R6 R7 array contents: %0d mismatching bytes, exp 0", bad);
      end
    end
    finish_run();
  end
endmodule